// File: doc/BRIEF.md
# Shared Interrupt Router with Masking

The block collects a parameterised number of external interrupt lines for a small multi-core cluster. Each line is conditioned by a per-source polarity and by a trigger type. It is then held as a pending bit, gated by a per-source enable bit, and steered to one core. Sources flagged as non-maskable instead go to every core at once. Every core receives three outputs: a flat vector of the sources it can currently see, a non-maskable flag, and an encoded pin value. The encoded pin value is zero when nothing is pending. Otherwise it is the selected pin number plus one.

Software reaches the block through a simple 32-bit write/read register port with a fixed 12-bit byte-address map. A read-only information word at 0x000 reports the source and core counts. Enable bits change through set and clear operations that take a source index, at 0x004 and 0x008. A software-trigger register at 0x00C raises or drops a soft request for one source. Pending words from 0x100 return the pending bits, and a write of ones there clears latched edges. Enable words from 0x180 return the enable bits. Per-source configuration words start at 0x200 and per-source core selectors start at 0x800, four bytes per source. Reads are combinational and writes take effect at the clock edge.

Top module: `irq_router`

## Requirements
- R1: After reset every source configuration word reads 0 (active high, level triggered, no valid pin, not non-maskable). All enable bits are 0 and all core routes are empty, so core_pin, core_nmi and core_pend are all 0.
- R2: The word at 0x000 reads NUM_SRC/8-1 in bits [7:0] and NUM_CORE-1 in bits [15:8], with all other bits 0.
- R3: Bit 0 of the configuration word at 0x200+4*i selects active-low sensing for source i. The conditioned input is the raw line XOR this bit, ORed with the source's soft request.
- R4: With bit 1 of the configuration word clear, the source is level triggered. Its pending bit equals the conditioned input one clock earlier, whether or not the source is enabled. Pending bit i reads back at bit i%32 of the word at 0x100+4*(i/32).
- R5: With bit 1 set, the source is edge triggered. A rising conditioned input sets the pending bit at the next edge, and the bit holds after the input falls. It clears on a write of a one to its bit at 0x100+4*(i/32), or on a soft-request clear for that source. A new edge in the same cycle as a clear wins.
- R6: Writing index i to 0x004 sets enable bit i, and writing index i to 0x008 clears it. Enable bits read back at 0x180+4*(i/32).
- R7: A write to 0x00C with bit 31 set raises the soft request of the source in bits [6:0]. With bit 31 clear, the write drops that request and also clears the source's latched edge.
- R8: Writing core index k to 0x800+4*i routes source i to core k only. The word reads back as a one-hot core bitmap. An index of NUM_CORE or above leaves the source routed to no core.
- R9: Bit c*NUM_SRC+i of core_pend is set exactly when source i is pending and enabled and is either routed to core c or non-maskable.
- R10: Bit 31 of the configuration word marks a valid pin, and bits [8+PIN_W-1:8] hold the pin number. The core_pin field of core c carries one plus the highest valid pin number among the non-NMI sources that core c sees, or 0 if there are none.
- R11: Bit 30 of the configuration word marks a source as non-maskable. Such a source, once pending and enabled, appears to every core and raises core_nmi on every core. It never contributes to core_pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_in | input | NUM_SRC | Raw external interrupt lines |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Register write byte address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 12 | Register read byte address |
| rd_data | output | 32 | Register read data (combinational) |
| core_pin | output | NUM_CORE*(PIN_W+1) | Per-core encoded pin, pin number plus one, 0 for none |
| core_pend | output | NUM_CORE*NUM_SRC | Per-core visible source vector |
| core_nmi | output | NUM_CORE | Per-core non-maskable flag |

## Verification
The bench builds the block with 16 sources, 2 cores and 4-bit pin numbers. With 16 sources the whole pending and enable state fits in a single register word, and the information word reads 0x0101. Two cores are enough to show a source that reaches one core and not the other, and to show a non-maskable source appearing on both. With 4-bit pins the top pin, 15, encodes as 16 and so uses the extra output bit. The setup mixes polarities, trigger types, a tie on the same pin and a configured but disabled source.

// File: rtl/irq_rtr_pkg.sv
`timescale 1ns/1ps
// Package: address map, field positions and address decode for the router.
// Assumes a 12-bit byte address and 32-bit data on the register port.
package irq_rtr_pkg;
    localparam int unsigned ADDR_W = 12;
    localparam int unsigned DATA_W = 32;

    localparam logic [ADDR_W-1:0] A_INFO   = 12'h000;
    localparam logic [ADDR_W-1:0] A_EN_SET = 12'h004;
    localparam logic [ADDR_W-1:0] A_EN_CLR = 12'h008;
    localparam logic [ADDR_W-1:0] A_SOFT   = 12'h00C;

    // configuration word field positions
    localparam int unsigned F_ACT_LOW = 0;
    localparam int unsigned F_EDGE    = 1;
    localparam int unsigned F_PIN_LSB = 8;
    localparam int unsigned F_NMI     = 30;
    localparam int unsigned F_VALID   = 31;
    localparam int unsigned F_SOFT_ON = 31;

    typedef enum logic [3:0] {
        RG_NONE, RG_INFO, RG_EN_SET, RG_EN_CLR, RG_SOFT,
        RG_PEND, RG_EN, RG_CFG, RG_ROUTE
    } region_e;

    // Classify a byte address into a register region.
    function automatic region_e decode(input logic [ADDR_W-1:0] a);
        region_e r;
        if (a == A_INFO)                r = RG_INFO;
        else if (a == A_EN_SET)         r = RG_EN_SET;
        else if (a == A_EN_CLR)         r = RG_EN_CLR;
        else if (a == A_SOFT)           r = RG_SOFT;
        else if (a[11:7] == 5'b00010)   r = RG_PEND;
        else if (a[11:7] == 5'b00011)   r = RG_EN;
        else if (a[11:9] == 3'b001)     r = RG_CFG;
        else if (a[11:9] == 3'b100)     r = RG_ROUTE;
        else                            r = RG_NONE;
        return r;
    endfunction
endpackage

// File: rtl/irq_src_cond.sv
`timescale 1ns/1ps
// Module: one source's conditioning and pending state.
// Level mode registers the conditioned input; edge mode latches a rising
// conditioned input until cleared. A new edge beats a clear in the same cycle.
// Assumes the raw line is already synchronous to clk.
module irq_src_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    input  logic act_low,
    input  logic edge_mode,
    input  logic soft_req,
    input  logic clr,
    output logic pend
);
    logic cond;
    logic prev_q;
    logic pend_q;

    assign cond = (raw_in ^ act_low) | soft_req;
    assign pend = pend_q;

    // Track the previous conditioned value and update the pending bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            prev_q <= cond;
            if (!edge_mode)
                pend_q <= cond;
            else if (cond && !prev_q)
                pend_q <= 1'b1;
            else if (clr)
                pend_q <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_pin_encode.sv
`timescale 1ns/1ps
// Module: per-core pin selector. Picks the highest pin among eligible
// sources and outputs pin+1, or 0 when none is eligible. The strict
// compare keeps the lowest source index on ties.
module irq_pin_encode #(
    parameter int unsigned NUM_SRC = 16,
    parameter int unsigned PIN_W   = 4
) (
    input  logic [NUM_SRC-1:0]            elig,
    input  logic [NUM_SRC-1:0][PIN_W-1:0] pin,
    output logic [PIN_W:0]                code
);
    // Scan all sources and keep the best encoded value.
    always_comb begin
        code = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (elig[i] && (({1'b0, pin[i]} + 1'b1) > code))
                code = {1'b0, pin[i]} + 1'b1;
        end
    end
endmodule

// File: rtl/irq_router.sv
`timescale 1ns/1ps
// Module: shared interrupt router top. Holds per-source configuration,
// enable, soft request and routing; conditions each source, gates it per
// core, and encodes a pin per core. Assumes NUM_SRC a multiple of 8 and
// at most 128, NUM_CORE at most 256, PIN_W at most 8.
module irq_router #(
    parameter int unsigned NUM_SRC  = 16,
    parameter int unsigned NUM_CORE = 2,
    parameter int unsigned PIN_W    = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_SRC-1:0]             src_in,
    input  logic                           wr_en,
    input  logic [11:0]                    wr_addr,
    input  logic [31:0]                    wr_data,
    input  logic [11:0]                    rd_addr,
    output logic [31:0]                    rd_data,
    output logic [NUM_CORE*(PIN_W+1)-1:0]  core_pin,
    output logic [NUM_CORE*NUM_SRC-1:0]    core_pend,
    output logic [NUM_CORE-1:0]            core_nmi
);
    import irq_rtr_pkg::*;

    localparam int unsigned NUM_W    = (NUM_SRC + 31) / 32;
    localparam int unsigned INFO_VAL = ((NUM_CORE - 1) << 8) | (NUM_SRC / 8 - 1);

    logic [NUM_SRC-1:0]                act_low_q, edge_q, pin_ok_q, nmi_q, en_q, sw_q;
    logic [NUM_SRC-1:0][PIN_W-1:0]     pin_q;
    logic [NUM_SRC-1:0][NUM_CORE-1:0]  route_q;
    logic [NUM_SRC-1:0]                pend, clr;
    logic [NUM_W*32-1:0]               pend_pad, en_pad;
    region_e                           wr_rg, rd_rg;
    logic [6:0]                        wr_slot, rd_slot, wr_idx;
    logic                              unused_bits;

    assign wr_rg    = decode(wr_addr);
    assign rd_rg    = decode(rd_addr);
    assign wr_slot  = wr_addr[8:2];
    assign rd_slot  = rd_addr[8:2];
    assign wr_idx   = wr_data[6:0];
    assign pend_pad = (NUM_W*32)'(pend);
    assign en_pad   = (NUM_W*32)'(en_q);
    assign unused_bits = ^{wr_data, wr_addr[1:0], rd_addr[1:0]};

    // Register writes: configuration, routing, enable and soft requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_low_q <= '0; edge_q <= '0; pin_ok_q <= '0; nmi_q <= '0;
            en_q <= '0; sw_q <= '0; pin_q <= '0; route_q <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < NUM_SRC; i++) begin
                case (wr_rg)
                    RG_EN_SET: if (int'(wr_idx) == i) en_q[i] <= 1'b1;
                    RG_EN_CLR: if (int'(wr_idx) == i) en_q[i] <= 1'b0;
                    RG_SOFT:   if (int'(wr_idx) == i) sw_q[i] <= wr_data[F_SOFT_ON];
                    RG_CFG: if (int'(wr_slot) == i) begin
                        act_low_q[i] <= wr_data[F_ACT_LOW];
                        edge_q[i]    <= wr_data[F_EDGE];
                        pin_ok_q[i]  <= wr_data[F_VALID];
                        nmi_q[i]     <= wr_data[F_NMI];
                        pin_q[i]     <= wr_data[F_PIN_LSB +: PIN_W];
                    end
                    RG_ROUTE: if (int'(wr_slot) == i) begin
                        for (int c = 0; c < NUM_CORE; c++)
                            route_q[i][c] <= (wr_data[7:0] == 8'(c));
                    end
                    default: ;
                endcase
            end
        end
    end

    // Clear strobes for latched edges: write-one at a pending word or soft drop.
    always_comb begin
        for (int i = 0; i < NUM_SRC; i++) begin
            clr[i] = wr_en && (
                (wr_rg == RG_PEND && int'(wr_addr[6:2]) == i / 32 && wr_data[i % 32]) ||
                (wr_rg == RG_SOFT && !wr_data[F_SOFT_ON] && int'(wr_idx) == i));
        end
    end

    // Read mux over all register regions.
    always_comb begin
        rd_data = '0;
        case (rd_rg)
            RG_INFO: rd_data = 32'(INFO_VAL);
            RG_PEND: if (int'(rd_addr[6:2]) < NUM_W) rd_data = pend_pad[int'(rd_addr[6:2])*32 +: 32];
            RG_EN:   if (int'(rd_addr[6:2]) < NUM_W) rd_data = en_pad[int'(rd_addr[6:2])*32 +: 32];
            RG_CFG: for (int i = 0; i < NUM_SRC; i++) begin
                if (int'(rd_slot) == i) begin
                    rd_data[F_ACT_LOW] = act_low_q[i];
                    rd_data[F_EDGE]    = edge_q[i];
                    rd_data[F_VALID]   = pin_ok_q[i];
                    rd_data[F_NMI]     = nmi_q[i];
                    rd_data[F_PIN_LSB +: PIN_W] = pin_q[i];
                end
            end
            RG_ROUTE: for (int i = 0; i < NUM_SRC; i++) begin
                if (int'(rd_slot) == i) rd_data[NUM_CORE-1:0] = route_q[i];
            end
            default: ;
        endcase
    end

    // Per-source conditioning and pending state.
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        irq_src_cond u_cond (
            .clk(clk), .rst_n(rst_n), .raw_in(src_in[i]),
            .act_low(act_low_q[i]), .edge_mode(edge_q[i]),
            .soft_req(sw_q[i]), .clr(clr[i]), .pend(pend[i])
        );
    end

    // Per-core visibility, non-maskable flag and pin encoding.
    for (genvar c = 0; c < NUM_CORE; c++) begin : g_core
        logic [NUM_SRC-1:0] vis;
        logic [NUM_SRC-1:0] elig;
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_vis
            assign vis[i]  = pend[i] && en_q[i] && (nmi_q[i] || route_q[i][c]);
            assign elig[i] = vis[i] && !nmi_q[i] && pin_ok_q[i];
        end
        assign core_pend[c*NUM_SRC +: NUM_SRC] = vis;
        assign core_nmi[c] = |(vis & nmi_q);
        irq_pin_encode #(.NUM_SRC(NUM_SRC), .PIN_W(PIN_W)) u_enc (
            .elig(elig), .pin(pin_q), .code(core_pin[c*(PIN_W+1) +: PIN_W+1])
        );
    end
endmodule

// File: rtl/irq_router_chk.sv
`timescale 1ns/1ps
// Module: assertion checker for irq_router, attached by bind below.
// Relates the block's outputs to its pending, enable and routing state.
module irq_router_chk #(
    parameter int unsigned NUM_SRC  = 16,
    parameter int unsigned NUM_CORE = 2,
    parameter int unsigned PIN_W    = 4
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic [NUM_SRC-1:0]             src_in,
    input logic [NUM_CORE*(PIN_W+1)-1:0]  core_pin,
    input logic [NUM_CORE*NUM_SRC-1:0]    core_pend,
    input logic [NUM_CORE-1:0]            core_nmi,
    input logic [NUM_SRC-1:0]             pend,
    input logic [NUM_SRC-1:0]             en_q,
    input logic [NUM_SRC-1:0]             act_low_q,
    input logic [NUM_SRC-1:0]             edge_q,
    input logic [NUM_SRC-1:0]             sw_q,
    input logic [NUM_SRC-1:0]             nmi_q,
    input logic [NUM_SRC-1:0][NUM_CORE-1:0] route_q
);
    AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (core_pin == '0 && core_nmi == '0 && core_pend == '0)); // R1

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        AST_LEVEL_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && !edge_q[i] && $past(!edge_q[i]))
            |-> pend[i] == $past((src_in[i] ^ act_low_q[i]) | sw_q[i])); // R4
        AST_ROUTE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(route_q[i])); // R8
        AST_NMI_EVERYWHERE: assert property (@(posedge clk) disable iff (!rst_n)
            (pend[i] && en_q[i] && nmi_q[i]) |-> core_nmi == '1); // R11
        for (genvar c = 0; c < NUM_CORE; c++) begin : g_core
            AST_VIS_GATED: assert property (@(posedge clk) disable iff (!rst_n)
                core_pend[c*NUM_SRC+i] |-> (pend[i] && en_q[i] && (nmi_q[i] || route_q[i][c]))); // R9
        end
    end

    for (genvar c = 0; c < NUM_CORE; c++) begin : g_pin
        AST_PIN_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
            (core_pin[c*(PIN_W+1) +: PIN_W+1] != '0) |-> (core_pend[c*NUM_SRC +: NUM_SRC] != '0)); // R10
    end
endmodule

bind irq_router irq_router_chk #(.NUM_SRC(NUM_SRC), .NUM_CORE(NUM_CORE), .PIN_W(PIN_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .core_pin(core_pin),
    .core_pend(core_pend), .core_nmi(core_nmi), .pend(pend), .en_q(en_q),
    .act_low_q(act_low_q), .edge_q(edge_q), .sw_q(sw_q), .nmi_q(nmi_q),
    .route_q(route_q)
);

// File: tb/sim_irq_router.sv
`timescale 1ns/1ps
// Bench: table-driven level/NMI walk, then directed reset and corner tests.
module sim_irq_router;
    localparam int N = 16;
    localparam int C = 2;
    localparam int P = 4;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [N-1:0]       src_in = '0;
    logic               wr_en = 1'b0;
    logic [11:0]        wr_addr = '0;
    logic [31:0]        wr_data = '0;
    logic [11:0]        rd_addr = '0;
    logic [31:0]        rd_data;
    logic [C*(P+1)-1:0] core_pin;
    logic [C*N-1:0]     core_pend;
    logic [C-1:0]       core_nmi;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // vector: [31:16] src_in, [15:11] core0 pin, [10:6] core1 pin, [5:4] core_nmi
    localparam logic [31:0] VEC [9] = '{
        32'h00040000, 32'h00052000, 32'h00074000, 32'h000000C0, 32'h00440000,
        32'h00154000, 32'h000120C0, 32'h00240030, 32'h00274030
    };

    irq_router #(.NUM_SRC(N), .NUM_CORE(C), .PIN_W(P)) u0 (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .core_pin(core_pin), .core_pend(core_pend),
        .core_nmi(core_nmi)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [11:0] a, input logic [31:0] exp);
        rd_addr = a;
        #0.5;
        check(tag, rd_data, exp);
    endtask

    function automatic logic [31:0] pin_of(input int c);
        return 32'(core_pin[c*(P+1) +: P+1]);
    endfunction

    initial begin
        #(200000 * 5);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
            $finish;
        end
    end

    initial begin
        src_in = 16'h00FF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1: reset defaults
        check("R1 core_pin", 32'(core_pin), 0);
        check("R1 core_nmi", 32'(core_nmi), 0);
        check("R1 core_pend", core_pend, 0);
        rd("R1 cfg default", 12'h200, 0);
        rd("R1 enable word", 12'h180, 0);
        rd("R1 route default", 12'h800, 0);
        rd("R4 level pending while masked", 12'h100, 32'h00FF);
        rd("R2 info word", 12'h000, 32'h0101);

        src_in = 16'h0004;
        wr(12'h200, 32'h80000300); wr(12'h800, 0);
        wr(12'h204, 32'h80000700); wr(12'h804, 0);
        wr(12'h208, 32'h80000201); wr(12'h808, 1);
        wr(12'h20C, 32'h80000502); wr(12'h80C, 1);
        wr(12'h210, 32'h80000700); wr(12'h810, 0);
        wr(12'h214, 32'h40000000); wr(12'h814, 0);
        wr(12'h218, 32'h80000F00); wr(12'h818, 1);
        wr(12'h81C, 5);
        for (int i = 0; i < 6; i++) wr(12'h004, 32'(i));
        @(negedge clk);
        rd("R3 cfg readback", 12'h208, 32'h80000201);
        rd("R8 route one-hot", 12'h808, 32'h2);
        rd("R8 route out of range", 12'h81C, 0);
        rd("R6 enable word", 12'h180, 32'h3F);

        // table walk: R3 polarity, R9/R10 routing and pin choice, R11 nmi
        for (int v = 0; v < 9; v++) begin
            src_in = VEC[v][31:16];
            @(negedge clk);
            check($sformatf("R10 row %0d core0 pin", v), pin_of(0), 32'(VEC[v][15:11]));
            check($sformatf("R10 row %0d core1 pin", v), pin_of(1), 32'(VEC[v][10:6]));
            check($sformatf("R11 row %0d nmi", v), 32'(core_nmi), 32'(VEC[v][5:4]));
            if (v == 6) check("R9 visible vector", core_pend, 32'h00040001);
            if (v == 7) check("R11 nmi on both cores", core_pend, 32'h00200020);
        end

        // R5: edge latch, hold, write-one-to-clear
        src_in = 16'h000C;
        @(negedge clk);
        check("R5 edge latched", pin_of(1), 6);
        src_in = 16'h0004;
        repeat (2) @(negedge clk);
        check("R5 edge held", pin_of(1), 6);
        rd("R5 pending word", 12'h100, 32'h0008);
        wr(12'h100, 32'h0008);
        check("R5 w1c clears", pin_of(1), 0);

        // R7: soft request on edge and level sources
        wr(12'h00C, 32'h80000003);
        @(negedge clk);
        check("R7 soft edge raise", pin_of(1), 6);
        wr(12'h00C, 32'h00000003);
        @(negedge clk);
        check("R7 soft drop clears edge", pin_of(1), 0);
        wr(12'h00C, 32'h80000000);
        @(negedge clk);
        check("R7 soft level raise", pin_of(0), 4);
        wr(12'h00C, 32'h00000000);
        @(negedge clk);
        check("R7 soft level drop", pin_of(0), 0);

        // R6: enable clear hides an active source
        src_in = 16'h0005;
        @(negedge clk);
        check("R6 enabled active", pin_of(0), 4);
        wr(12'h008, 0);
        @(negedge clk);
        check("R6 cleared hides pin", pin_of(0), 0);
        check("R6 cleared hides pend", core_pend, 0);
        rd("R6 enable word after clear", 12'h180, 32'h3E);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule